// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block models one logic block of a small programmable device as ordinary synchronous logic whose function comes from a configuration image. Eighteen routed input signals go into a programmable AND plane. That plane forms twenty data product terms and three control terms. Each of four macrocells builds its output from those terms and can hold the result in a register. The macrocell outputs leave the block so that surrounding interconnect can feed them back to any block's inputs.

Each macrocell takes one of two paths. The fast path ORs four terms that belong only to that macrocell. The wide path ORs any subset of all twenty data terms, so terms are shared across macrocells, and then passes the sum through an XOR with a polarity bit. The registers change state on a rising edge of a chosen clock source. That source is one of three global clock inputs or a product term. The edge is detected against the system clock `clk`. One control term clears the registers and another drives the output enable. The configuration is written word by word over a parallel bus, normally right after reset, and is left alone while the block runs.

Top module: `plb_logic_block`

## Requirements
- R1: Configuration row bits 2i and 2i+1 select the true and the complemented copy of input i for a product term. The term is the AND of the selected literals. A row with no bit set gives a term that is always 0.
- R2: In bypass mode (macrocell word bit 20 = 1), macrocell m outputs the OR of terms 5m to 5m+3. The mask, the polarity and term 5m+4 have no effect.
- R3: In wide mode (bit 20 = 0), macrocell m outputs the OR of the data terms 0 to 19 whose bits are set in mask bits 19:0, XORed with the polarity bit (bit 21).
- R4: With bit 22 = 0 the output is combinational and follows the inputs with no clock event.
- R5: With bit 22 = 1 the output is the register. The register loads at the first `clk` edge that sees the selected source high after it was low. The source is chosen by block word bits 1:0: codes 0 to 2 pick `gclk[0..2]` and code 3 picks term 22.
- R6: Term 20 is the reset term. At any `clk` edge where it is true, the registers clear, and this overrides a load at the same edge.
- R7: `rst_n` low clears the registers and the whole configuration at once, with no clock, so every output and `dout_oe` read 0.
- R8: `dout_oe` equals term 21.
- R9: Words are stored only at a `clk` edge with `cfg_load` high. Rows are at addresses 0 to 22, macrocell words at 23 to 26, and the block word at 27. Writes to addresses 28 to 31 are dropped.
- R10: Between load events the register holds its value, including while the selected source stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of registers and configuration |
| cfg_load | input | 1 | Write strobe for the configuration word |
| cfg_addr | input | 5 | Configuration word address |
| cfg_data | input | 36 | Configuration word contents |
| din | input | 18 | Routed logic inputs |
| gclk | input | 3 | Global clock sources, edge-detected against `clk` |
| dout | output | 4 | Macrocell outputs, also the feedback signals |
| dout_oe | output | 1 | Output enable from the enable term |

## Verification
Some properties are checked on every cycle. The configuration stays stable when no write is strobed. A register changes only on a load event or a reset term, a reset term always leaves the register at zero, and a load stores the value the macrocell logic presented. The directed scenarios cover what those properties cannot show: the literal encoding, bypass versus shared wide sums, polarity, the clock-source codes, reset-term priority, dropped writes and the asynchronous reset of the configuration.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int N_IN     = 18;
  localparam int N_MC     = 4;
  localparam int PT_PER   = 5;
  localparam int BYP_PT   = 4;
  localparam int N_GCLK   = 3;
  localparam int N_DPT    = N_MC * PT_PER;
  localparam int PT_RST   = N_DPT;
  localparam int PT_OE    = N_DPT + 1;
  localparam int PT_CLK   = N_DPT + 2;
  localparam int N_PT     = N_DPT + 3;
  localparam int CW       = 2 * N_IN;
  localparam int ADDR_MC  = N_PT;
  localparam int ADDR_BLK = N_PT + N_MC;
  localparam int AW       = $clog2(ADDR_BLK + 1);
  localparam int CSW      = $clog2(N_GCLK + 1);

  typedef struct packed {
    logic             reg_en;
    logic             pol;
    logic             bypass;
    logic [N_DPT-1:0] mask;
  } mc_cfg_t;
endpackage

// File: rtl/plb_cfg_store.sv
module plb_cfg_store
  import plb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CW-1:0]       cfg_data,
  output logic [N_PT-1:0][CW-1:0] rows,
  output mc_cfg_t [N_MC-1:0]  mc_cfg,
  output logic [CSW-1:0]      clk_sel
);
  localparam int MCW = $bits(mc_cfg_t);

  for (genvar p = 0; p < N_PT; p++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rows[p] <= '0;
      else if (cfg_load && cfg_addr == AW'(p)) rows[p] <= cfg_data;
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mc_cfg[m] <= '0;
      else if (cfg_load && cfg_addr == AW'(ADDR_MC + m)) mc_cfg[m] <= mc_cfg_t'(cfg_data[MCW-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_sel <= '0;
    else if (cfg_load && cfg_addr == AW'(ADDR_BLK)) clk_sel <= cfg_data[CSW-1:0];
  end

  // R9: configuration is frozen without a strobe
  a_r9_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(rows) && $stable(mc_cfg) && $stable(clk_sel)));
endmodule

// File: rtl/plb_and_array.sv
module plb_and_array
  import plb_pkg::*;
(
  input  logic [N_IN-1:0]         din,
  input  logic [N_PT-1:0][CW-1:0] rows,
  output logic [N_PT-1:0]         pt
);
  logic [CW-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = din[i];
    assign lit[2*i+1] = ~din[i];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    assign pt[p] = (|rows[p]) & (&(lit | ~rows[p]));
  end
endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell
  import plb_pkg::*;
#(
  parameter int MC_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DPT-1:0] pt_data,
  input  mc_cfg_t          cfg,
  input  logic             cap,
  input  logic             clr,
  output logic             q
);
  localparam int BASE = MC_IDX * PT_PER;

  logic byp_sum, wide_sum, d, q_reg;

  assign byp_sum  = |pt_data[BASE +: BYP_PT];
  assign wide_sum = (|(pt_data & cfg.mask)) ^ cfg.pol;
  assign d        = cfg.bypass ? byp_sum : wide_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_reg <= 1'b0;
    else if (clr) q_reg <= 1'b0;
    else if (cap) q_reg <= d;
  end

  assign q = cfg.reg_en ? q_reg : d;

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_reg == 1'b0));
  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clr) |=> (q_reg == $past(d)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clr) |=> $stable(q_reg));
endmodule

// File: rtl/plb_logic_block.sv
module plb_logic_block
  import plb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [4:0]           cfg_addr,
  input  logic [35:0]          cfg_data,
  input  logic [17:0]          din,
  input  logic [2:0]           gclk,
  output logic [3:0]           dout,
  output logic                 dout_oe
);
  logic [N_PT-1:0][CW-1:0] rows;
  mc_cfg_t [N_MC-1:0]      mc_cfg;
  logic [CSW-1:0]          clk_sel;
  logic [N_PT-1:0]         pt;
  logic                    src, src_q, cap;

  plb_cfg_store i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .rows(rows), .mc_cfg(mc_cfg), .clk_sel(clk_sel)
  );

  plb_and_array i_arr (.din(din), .rows(rows), .pt(pt));

  always_comb begin
    src = pt[PT_CLK];
    for (int g = 0; g < N_GCLK; g++)
      if (clk_sel == CSW'(g)) src = gclk[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign cap = src & ~src_q;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    plb_macrocell #(.MC_IDX(m)) i_mc (
      .clk(clk), .rst_n(rst_n), .pt_data(pt[N_DPT-1:0]), .cfg(mc_cfg[m]),
      .cap(cap), .clr(pt[PT_RST]), .q(dout[m])
    );
  end

  assign dout_oe = pt[PT_OE];
endmodule

// File: tb/test_plb_logic_block.sv
module test_plb_logic_block;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [35:0] cfg_data = '0;
  logic [17:0] din = '0;
  logic [2:0]  gclk = '0;
  logic [3:0]  dout;
  logic        dout_oe;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  plb_logic_block i_plb_logic_block (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .din(din), .gclk(gclk), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [35:0] lt(int i); return 36'd1 << (2*i); endfunction
  function automatic logic [35:0] lc(int i); return 36'd1 << (2*i+1); endfunction
  function automatic logic [35:0] mcw(bit r, bit p, bit b, logic [19:0] mask);
    return {13'd0, r, p, b, mask};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [35:0] d);
    @(negedge clk); cfg_load = 1'b1; cfg_addr = 5'(a); cfg_data = d;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic t_reset;
    rst_n = 1'b1; #1 rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    check("R7 reset", {dout_oe, dout}, 5'b0);
  endtask

  task automatic t_config;
    wr(0, lt(0) | lc(1));
    wr(1, lt(2));
    wr(3, lt(5) | lc(5));
    wr(4, lt(3));
    wr(9, lt(4));
    wr(10, lt(6));
    wr(20, lt(8));
    wr(21, lt(9));
    wr(22, lt(7));
    wr(23, mcw(0, 1, 1, 20'hFFFFF));
    wr(24, mcw(0, 1, 0, 20'h00201));
    wr(25, mcw(1, 0, 0, 20'h00400));
    wr(27, 36'd1);
  endtask

  task automatic t_bypass;
    din = '0; #1 check("R2 bypass idle", {4'b0, dout[0]}, 5'b0);
    din = 18'b1; #1 check("R1 R2 true literal", {4'b0, dout[0]}, 5'b1);
    din = 18'b11; #1 check("R1 complement literal", {4'b0, dout[0]}, 5'b0);
    din = 18'b100; #1 check("R2 second term", {4'b0, dout[0]}, 5'b1);
    din = 18'b1000; #1 check("R2 fifth term excluded", {4'b0, dout[0]}, 5'b0);
    din = 18'b100000; #1 check("R1 contradictory term", {4'b0, dout[0]}, 5'b0);
    din = '0;
  endtask

  task automatic t_wide;
    din = '0; #1 check("R3 R4 inverted empty sum", {4'b0, dout[1]}, 5'b1);
    din = 18'b10000; #1 check("R3 own term", {4'b0, dout[1]}, 5'b0);
    din = 18'b1; #1 check("R3 shared term", {4'b0, dout[1]}, 5'b0);
    din = '0; #1 check("R3 unused macrocell", {4'b0, dout[3]}, 5'b0);
  endtask

  task automatic t_register;
    din = 18'h40; cyc(2);
    check("R5 no event", {4'b0, dout[2]}, 5'b0);
    gclk = 3'b001; cyc(1); gclk = 3'b000; cyc(1);
    check("R5 unselected clock", {4'b0, dout[2]}, 5'b0);
    gclk = 3'b010; cyc(1);
    check("R5 selected edge", {4'b0, dout[2]}, 5'b1);
    din = '0; cyc(3);
    check("R10 level holds", {4'b0, dout[2]}, 5'b1);
    gclk = 3'b000; cyc(1); gclk = 3'b010; cyc(1);
    check("R5 second edge", {4'b0, dout[2]}, 5'b0);
    gclk = 3'b000;
    wr(27, 36'd3);
    din = 18'h40; cyc(1);
    check("R5 term clock idle", {4'b0, dout[2]}, 5'b0);
    din = 18'hC0; cyc(1);
    check("R5 term clock edge", {4'b0, dout[2]}, 5'b1);
  endtask

  task automatic t_clear;
    din = 18'h40; cyc(1);
    din = 18'h1C0; cyc(1);
    check("R6 clear over load", {4'b0, dout[2]}, 5'b0);
    din = 18'h0C0; cyc(2);
    check("R10 no event after clear", {4'b0, dout[2]}, 5'b0);
    din = '0; cyc(1);
  endtask

  task automatic t_oe;
    din = 18'h200; #1 check("R8 enable high", {4'b0, dout_oe}, 5'b1);
    din = '0; #1 check("R8 enable low", {4'b0, dout_oe}, 5'b0);
  endtask

  task automatic t_cfg_guard;
    @(negedge clk); cfg_addr = 5'd24; cfg_data = '1; cyc(2);
    check("R9 no strobe", {4'b0, dout[1]}, 5'b1);
    wr(30, '1); wr(31, '1); cyc(1);
    check("R9 dropped address", {3'b0, dout[3], dout[1]}, 5'b01);
  endtask

  task automatic t_async;
    din = 18'h40; cyc(1); din = 18'hC0; cyc(1);
    check("R5 setup for reset", {4'b0, dout[2]}, 5'b1);
    din = 18'h2C0; #1 rst_n = 1'b0; #1;
    check("R7 async clear", {dout_oe, dout}, 5'b0);
    cyc(1); rst_n = 1'b1; din = '1; cyc(1);
    check("R7 config cleared", {dout_oe, dout}, 5'b0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_config; t_bypass; t_wide; t_register;
        t_clear; t_oe; t_cfg_guard; t_async;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule